// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches sixteen interrupt lines. Each line takes its input from one of up to eleven GPIO ports. A 4-bit source field per line chooses the port, and line n always uses pin n of the chosen port. The selected pin passes through a two-flop synchronizer. Its rising and falling edges are then detected against the previous synchronized sample. An edge that the line's trigger enables allow sets a sticky pending flag. Software clears that flag by writing 1 to it.

Each line has two outputs. The interrupt output is the pending flag gated by an interrupt mask. The event output is a one-cycle pulse on each enabled edge, gated by a separate event mask, and it does not depend on the pending flag.

A flat word-addressed register interface configures the block and reads it back. The write is a single-cycle strobe, and read data is combinational from the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, every line selects code 0, and `irq_o` and `evt_o` are 0.
- R2: With its rise-enable bit set (register address 0, bit n = line n), a 0→1 change on line n's selected pin sets pending bit n. The bit is visible on the third rising clock edge after the pin change.
- R3: The fall-enable register (address 1) is independent of the rise-enable register. A line with only fall enabled triggers on 1→0, and a line with both bits set triggers on either edge.
- R4: An edge on a line whose enable for that edge direction is clear leaves its pending bit unchanged.
- R5: A pending bit (address 4) is set even when the interrupt mask (address 2) is clear. `irq_o[n]` equals pending bit n AND mask bit n.
- R6: When event-mask bit n (address 3) is set, an enabled edge on line n drives `evt_o[n]` high for exactly one cycle, in the same cycle the pending bit first reads 1. This happens whether or not the bit was already pending. With the mask bit clear, `evt_o[n]` stays 0.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged, and a write can never set a pending bit.
- R8: When an enabled edge and a clearing write to the same pending bit take effect on the same clock edge, the bit ends up set.
- R9: The source code for line n sits in the select register at address 5 + n/4, bits [4*(n mod 4)+3 : 4*(n mod 4)]. Code k in 0..10 selects `gpio_i[16*k + n]`. Bits [31:16] of a select register read 0.
- R10: Codes 11 to 15 hold the line's input low, so no pin change on any port triggers that line.
- R11: Changing a line's source code never creates an edge by itself, even when the old and new pins differ in level.
- R12: Trigger, mask and select registers read back the written value in their implemented bits, and read 0 above bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| gpio_i | input | 176 | Pin inputs, port k pin n at bit 16*k+n |
| irq_o | output | 16 | Per-line interrupt request |
| evt_o | output | 16 | Per-line one-cycle event pulse |

## Verification
The hardest cases to reach from the ports are the ones that depend on exact cycle alignment.

- **Set wins over clear (R8).** The clearing write has to land on the same clock edge on which the edge detector reports. The bench raises a pin, counts two clock edges through the synchronizer, and places a write-1 strobe on the third edge.
- **Source switch (R11).** The bench holds the new source pin high for many cycles while the old one stays low, then switches the select field. It checks that nothing becomes pending, and then shows that a real edge on the new pin still registers.
- **Source mapping (R9, R10).** A sweep over every line and every code checks the field placement and the dead codes.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int SEL_W         = 4;
  localparam int LINES_PER_SEL = 4;
  localparam int ADDR_RISE     = 0;
  localparam int ADDR_FALL     = 1;
  localparam int ADDR_IMASK    = 2;
  localparam int ADDR_EMASK    = 3;
  localparam int ADDR_PEND     = 4;
  localparam int ADDR_SEL_BASE = 5;
endpackage

// File: rtl/eic_src_mux.sv
module eic_src_mux
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 11
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_i,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_i,
  output logic [NUM_LINES-1:0]           line_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_comb begin
      line_o[l] = 1'b0;  // unused codes hold low
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel_i[l*SEL_W +: SEL_W] == SEL_W'(p)) line_o[l] = gpio_i[p*NUM_LINES + l];
      end
    end
  end
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det
  import eic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic sync1_q, sync2_q, prev_q;
  logic [SEL_W-1:0] sel_seen_q;
  logic flush;

  // source changed: reload history from the new pin, suppress edges
  assign flush = (sel_i != sel_seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q    <= 1'b0;
      sync2_q    <= 1'b0;
      prev_q     <= 1'b0;
      sel_seen_q <= '0;
    end else if (flush) begin
      sync1_q    <= pin_i;
      sync2_q    <= pin_i;
      prev_q     <= pin_i;
      sel_seen_q <= sel_i;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise_o = ~flush &  sync2_q & ~prev_q;
  assign fall_o = ~flush & ~sync2_q &  prev_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_LINES-1:0]       rise_i,
  input  logic [NUM_LINES-1:0]       fall_i,
  output logic [NUM_LINES*SEL_W-1:0] sel_o,
  output logic [NUM_LINES-1:0]       irq_o,
  output logic [NUM_LINES-1:0]       evt_o
);
  localparam int NUM_SEL = NUM_LINES / LINES_PER_SEL;
  localparam int SEL_BITS = LINES_PER_SEL * SEL_W;

  logic [NUM_LINES-1:0] rise_en_q, fall_en_q, imask_q, emask_q, pend_q, evt_q;
  logic [NUM_LINES-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [NUM_LINES-1:0] hit, clr, pend_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_LINES];

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  assign hit    = (rise_i & rise_en_q) | (fall_i & fall_en_q);
  assign clr    = (we_i && hit_addr(addr_i, ADDR_PEND)) ? wdata_i[NUM_LINES-1:0] : '0;
  assign pend_d = (pend_q & ~clr) | hit;  // set wins

  always_comb begin
    sel_d = sel_q;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (we_i && hit_addr(addr_i, ADDR_SEL_BASE + l / LINES_PER_SEL))
        sel_d[l] = wdata_i[(l % LINES_PER_SEL)*SEL_W +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      imask_q   <= '0;
      emask_q   <= '0;
      pend_q    <= '0;
      evt_q     <= '0;
      sel_q     <= '0;
    end else begin
      if (we_i && hit_addr(addr_i, ADDR_RISE))  rise_en_q <= wdata_i[NUM_LINES-1:0];
      if (we_i && hit_addr(addr_i, ADDR_FALL))  fall_en_q <= wdata_i[NUM_LINES-1:0];
      if (we_i && hit_addr(addr_i, ADDR_IMASK)) imask_q   <= wdata_i[NUM_LINES-1:0];
      if (we_i && hit_addr(addr_i, ADDR_EMASK)) emask_q   <= wdata_i[NUM_LINES-1:0];
      pend_q <= pend_d;
      evt_q  <= hit & emask_q;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_addr(addr_i, ADDR_RISE))  rdata_o[NUM_LINES-1:0] = rise_en_q;
    if (hit_addr(addr_i, ADDR_FALL))  rdata_o[NUM_LINES-1:0] = fall_en_q;
    if (hit_addr(addr_i, ADDR_IMASK)) rdata_o[NUM_LINES-1:0] = imask_q;
    if (hit_addr(addr_i, ADDR_EMASK)) rdata_o[NUM_LINES-1:0] = emask_q;
    if (hit_addr(addr_i, ADDR_PEND))  rdata_o[NUM_LINES-1:0] = pend_q;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (hit_addr(addr_i, ADDR_SEL_BASE + k))
        for (int j = 0; j < LINES_PER_SEL; j++)
          rdata_o[j*SEL_W +: SEL_W] = sel_q[k*LINES_PER_SEL + j];
    end
    if (SEL_BITS > DATA_W) rdata_o = '0;
  end

  assign sel_o = sel_q;
  assign irq_o = pend_q & imask_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 11,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_we_i,
  input  logic [ADDR_W-1:0]              reg_addr_i,
  input  logic [DATA_W-1:0]              reg_wdata_i,
  output logic [DATA_W-1:0]              reg_rdata_o,
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_i,
  output logic [NUM_LINES-1:0]           irq_o,
  output logic [NUM_LINES-1:0]           evt_o
);
  logic [NUM_LINES*SEL_W-1:0] sel_flat;
  logic [NUM_LINES-1:0] line_in, rise, fall;

  eic_src_mux #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS)) u_mux (
    .gpio_i (gpio_i),
    .sel_i  (sel_flat),
    .line_o (line_in)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_det
    eic_edge_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (line_in[l]),
      .sel_i  (sel_flat[l*SEL_W +: SEL_W]),
      .rise_o (rise[l]),
      .fall_o (fall[l])
    );
  end

  eic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .rise_i  (rise),
    .fall_i  (fall),
    .sel_o   (sel_flat),
    .irq_o   (irq_o),
    .evt_o   (evt_o)
  );
endmodule

// File: rtl/eic_chk.sv
module eic_chk
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 11,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [NUM_LINES-1:0]       pend_i,
  input logic [NUM_LINES-1:0]       rise_en_i,
  input logic [NUM_LINES-1:0]       fall_en_i,
  input logic [NUM_LINES-1:0]       emask_i,
  input logic [NUM_LINES*SEL_W-1:0] sel_i,
  input logic [NUM_LINES-1:0]       evt_i
);
  logic [NUM_LINES-1:0] wclr, bad_sel;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:NUM_LINES];
  assign wclr = (we_i && addr_i == ADDR_W'(ADDR_PEND)) ? wdata_i[NUM_LINES-1:0] : '0;

  always_comb
    for (int l = 0; l < NUM_LINES; l++)
      bad_sel[l] = sel_i[l*SEL_W +: SEL_W] >= SEL_W'(NUM_PORTS);

  p_pend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(pend_i) & ~$past(wclr)) & ~pend_i) == '0));

  p_pend_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pend_i & ~$past(pend_i)) & ~($past(rise_en_i) | $past(fall_en_i))) == '0));

  p_evt_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & ~$past(emask_i)) == '0));

  p_evt_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & ~pend_i) == '0));

  p_bad_sel_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pend_i & ~$past(pend_i)) & $past(bad_sel)) == '0));
endmodule

bind edge_irq_ctrl eic_chk #(
  .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .pend_i    (u_regs.pend_q),
  .rise_en_i (u_regs.rise_en_q),
  .fall_en_i (u_regs.fall_en_q),
  .emask_i   (u_regs.emask_q),
  .sel_i     (sel_flat),
  .evt_i     (evt_o)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int NL = 16, NP = 11;
  localparam int A_RISE = 0, A_FALL = 1, A_IMASK = 2, A_EMASK = 3, A_PEND = 4, A_SEL = 5;

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP*NL-1:0] gpio = '0;
  logic [NL-1:0] irq, evt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gpio_i(gpio), .irq_o(irq), .evt_o(evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 4'(a); wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 4'(a); #1; d = rdata;
  endtask

  task automatic wait_sync;  // pin change -> pending/event visible
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 evt", 32'(evt), 0);
    for (int a = 0; a < 9; a++) begin rd(a, r); chk("R1 reg", r, 0); end

    // R12 readback
    wr(A_RISE, 32'hDEAD_BEEF);  rd(A_RISE, r);  chk("R12 rise", r, 32'h0000_BEEF);
    wr(A_FALL, 32'h1234_5678);  rd(A_FALL, r);  chk("R12 fall", r, 32'h0000_5678);
    wr(A_IMASK, 32'hFFFF_0F0F); rd(A_IMASK, r); chk("R12 imask", r, 32'h0000_0F0F);
    wr(A_EMASK, 32'h0000_A55A); rd(A_EMASK, r); chk("R12 emask", r, 32'h0000_A55A);
    wr(A_SEL+2, 32'hFFFF_9A3C); rd(A_SEL+2, r); chk("R12 R9 sel", r, 32'h0000_9A3C);
    // R7 a write cannot set pending
    wr(A_PEND, 32'h0000_FFFF); rd(A_PEND, r); chk("R7 no set", r, 0);
    for (int a = 0; a < 9; a++) wr(a, 0);
    idle(4);

    // R2 R9 R10 R6 sweep of every line and code
    wr(A_RISE, 32'hFFFF); wr(A_EMASK, 32'hFFFF);
    for (int l = 0; l < NL; l++) begin
      for (int p = 0; p < 16; p++) begin
        logic [NL-1:0] exp;
        wr(A_SEL + l/4, 32'(p) << (4*(l%4)));
        idle(1);
        if (p < NP) gpio[p*NL + l] = 1'b1;
        else for (int q = 0; q < NP; q++) gpio[q*NL + l] = 1'b1;
        exp = (p < NP) ? NL'(1) << l : '0;
        wait_sync;
        chk("R6 evt pulse", 32'(evt), 32'(exp));
        rd(A_PEND, r);
        chk((p < NP) ? "R2 R9 pend" : "R10 dead code", r, 32'(exp));
        @(negedge clk);
        chk("R6 evt single", 32'(evt), 0);
        gpio = '0;
        idle(4);
        wr(A_PEND, 32'hFFFF);
      end
      wr(A_SEL + l/4, 0);
    end
    rd(A_PEND, r); chk("R7 cleared", r, 0);

    // R3 R4 on line 3, port 0
    wr(A_RISE, 0); wr(A_EMASK, 0); wr(A_FALL, 32'h8);
    idle(2);
    gpio[3] = 1'b1; wait_sync; rd(A_PEND, r); chk("R4 rise ignored", r, 0);
    gpio[3] = 1'b0; wait_sync; rd(A_PEND, r); chk("R3 fall only", r, 32'h8);
    wr(A_PEND, 32'h8); wr(A_RISE, 32'h8);
    gpio[3] = 1'b1; wait_sync; rd(A_PEND, r); chk("R3 both rise", r, 32'h8);
    wr(A_PEND, 32'h8);
    gpio[3] = 1'b0; wait_sync; rd(A_PEND, r); chk("R3 both fall", r, 32'h8);
    wr(A_PEND, 32'hFFFF); wr(A_RISE, 0); wr(A_FALL, 0);

    // R8 set wins over same-cycle clear, line 2
    wr(A_RISE, 32'h4);
    idle(2);
    gpio[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_PEND, 32'h4);  // strobe lands on the third edge
    rd(A_PEND, r); chk("R8 set wins", r, 32'h4);
    // R7 write 0 no effect, write 1 clears
    wr(A_PEND, 0);     rd(A_PEND, r); chk("R7 zero write", r, 32'h4);
    wr(A_PEND, 32'h4); rd(A_PEND, r); chk("R7 w1c", r, 0);

    // R5 pending regardless of irq mask
    gpio[2] = 1'b0; idle(4);
    gpio[2] = 1'b1; wait_sync;
    rd(A_PEND, r); chk("R5 pend masked", r, 32'h4);
    chk("R5 irq masked", 32'(irq), 0);
    wr(A_IMASK, 32'h104);
    chk("R5 irq gated", 32'(irq), 32'h4);
    // R6 no event with mask clear, event again while already pending
    gpio[2] = 1'b0; idle(4);
    gpio[2] = 1'b1; wait_sync;
    chk("R6 evt off", 32'(evt), 0);
    wr(A_EMASK, 32'h4);
    gpio[2] = 1'b0; idle(4);
    gpio[2] = 1'b1; wait_sync;
    chk("R6 evt while pending", 32'(evt), 32'h4);
    @(negedge clk); chk("R6 evt one cycle", 32'(evt), 0);
    wr(A_PEND, 32'h4);
    chk("R5 irq cleared", 32'(irq), 0);
    gpio = '0; wr(A_RISE, 0); wr(A_EMASK, 0); wr(A_IMASK, 0);

    // R11 source switch creates no edge, line 5: port 0 low, port 1 high
    wr(A_RISE, 32'h20);
    gpio[NL + 5] = 1'b1;
    idle(5);
    wr(A_PEND, 32'hFFFF);
    wr(A_SEL + 1, 32'h10);  // line 5 field bits [7:4] = code 1
    idle(6);
    rd(A_PEND, r); chk("R11 no spurious", r, 0);
    gpio[NL + 5] = 1'b0; idle(4);
    gpio[NL + 5] = 1'b1; wait_sync;
    rd(A_PEND, r); chk("R11 R9 new source", r, 32'h20);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule